// File: doc/BRIEF.md
# Byte-Serial RC4 Keystream Generator

This block turns a short secret key into the RC4 pseudo-random byte stream. After reset it takes the key one byte per clock on an 8-bit input, for a fixed number of bytes set by a parameter. It then builds its 256-entry byte permutation with the RC4 key schedule. It does this at a fixed rate of three clocks per state index, so the schedule always takes 768 clocks.

When the schedule is done, the generator starts producing bytes. It drops the first 1536 of them internally, because the early RC4 output is statistically weak. From then on it delivers one fresh keystream byte on every clock, with a ready flag. To encrypt or decrypt, the surrounding logic XORs its data with this stream. The only way to load a new key is to apply reset.

Top module: `rc4_keystream`

## Requirements
- R1: While reset is high and right after it, `ks_ready` is 0 and `ks_byte` is 0. Reset in any phase, including during the output stream, returns the block to key loading.
- R2: Key byte m (m = 0 … KEY_SIZE-1) is the value on `key_byte` at the (m+1)-th rising edge after reset is released. Values on `key_byte` after that are ignored.
- R3: The key schedule is the standard RC4 one (S[i]=i, then j = j + S[i] + key[i mod KEY_SIZE], then swap S[i] and S[j], for i = 0 … 255). It takes exactly 768 clocks.
- R4: The first 1536 generated bytes are never presented. `ks_ready` first reads 1 after rising edge number KEY_SIZE + 2305, counted from the release of reset.
- R5: Once `ks_ready` is 1, it stays 1 until the next reset, and `ks_byte` carries a new keystream byte after every rising edge.
- R6: The bytes presented are RC4 output bytes 1536, 1537, … in order, for the loaded key. Generation starts with i = j = 0 and follows the standard step (i+1, j+S[i], swap, output S[S[i]+S[j]]).
- R7: Output stays correct when indices collide in one step: when i equals j, or when the output index S[i]+S[j] equals i or j.
- R8: After a reset that cuts off a schedule or discard in progress, a new key yields the correct stream for that key.
- R9: `ks_ready` is 0 during key loading, key scheduling and discard.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous active-high reset |
| key_byte | input | 8 | Key byte, sampled on each of the first KEY_SIZE edges after reset |
| ks_byte | output | 8 | Keystream byte |
| ks_ready | output | 1 | High when `ks_byte` holds a valid keystream byte |

## Verification
Each generation cycle both swaps two state entries and reads the output entry. The output read can land on one of the two entries that are being swapped in that same cycle, and i and j can also be equal. The bench provokes these cases by running long streams for a 5-byte and a 1-byte key, including all-zero and all-ones keys. Its own model counts how many valid steps had such a collision and requires that count to be nonzero. Every valid byte is judged against that model, so a wrong forwarding choice shows up as a byte mismatch.

// File: rtl/rc4_pkg.sv
package rc4_pkg;

  localparam int SBOX_N    = 256;
  localparam int STEP_N    = 3;
  localparam int DISCARD_N = 1536;

  typedef enum logic [1:0] {
    PH_LOAD  = 2'd0,
    PH_SCHED = 2'd1,
    PH_GEN   = 2'd2
  } phase_t;

  // key schedule index update
  function automatic logic [7:0] sched_j(input logic [7:0] j,
                                         input logic [7:0] s_i,
                                         input logic [7:0] k);
    return 8'(j + s_i + k);
  endfunction

  // output lookup index of a generation step
  function automatic logic [7:0] out_index(input logic [7:0] a,
                                           input logic [7:0] b);
    return 8'(a + b);
  endfunction

  // value at index t of the state after swapping entries ia and ib,
  // where ia received nb and ib received na
  function automatic logic [7:0] post_swap(input logic [7:0] t,
                                           input logic [7:0] ia,
                                           input logic [7:0] ib,
                                           input logic [7:0] nb,
                                           input logic [7:0] na,
                                           input logic [7:0] old_t);
    if (t == ia) return nb;
    if (t == ib) return na;
    return old_t;
  endfunction

endpackage

// File: rtl/rc4_key_store.sv
module rc4_key_store #(
  parameter int KEY_SIZE = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_en,
  input  logic [7:0] key_byte,
  input  logic       kstep,
  output logic [7:0] key_cur,
  output logic       load_last
);
  localparam int KW = (KEY_SIZE > 1) ? $clog2(KEY_SIZE) : 1;
  localparam logic [KW-1:0] KLAST = KW'(KEY_SIZE - 1);

  logic [7:0]    mem [KEY_SIZE];
  logic [KW-1:0] wptr, rptr;

  assign load_last = (wptr == KLAST);
  assign key_cur   = mem[rptr];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
    end else begin
      if (load_en && !load_last) wptr <= wptr + KW'(1);
      if (kstep) rptr <= (rptr == KLAST) ? '0 : rptr + KW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) mem[wptr] <= key_byte;
  end

endmodule

// File: rtl/rc4_ctrl.sv
module rc4_ctrl
  import rc4_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load_last,
  input  logic       i_last,
  output phase_t     phase,
  output logic [1:0] sub,
  output logic       discard_done
);
  localparam int DW = $clog2(DISCARD_N + 1);
  localparam logic [1:0] SUB_LAST = 2'(STEP_N - 1);

  logic [DW-1:0] dcnt;
  logic          sched_step_end;
  logic          sched_exit;

  assign sched_step_end = (phase == PH_SCHED) && (sub == SUB_LAST);
  assign sched_exit     = sched_step_end && i_last;
  assign discard_done   = (dcnt == DW'(DISCARD_N));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      phase <= PH_LOAD;
      sub   <= '0;
      dcnt  <= '0;
    end else begin
      case (phase)
        PH_LOAD:  if (load_last) phase <= PH_SCHED;
        PH_SCHED: begin
          sub <= sched_step_end ? 2'd0 : sub + 2'd1;
          if (sched_exit) phase <= PH_GEN;
        end
        PH_GEN:   if (!discard_done) dcnt <= dcnt + DW'(1);
        default:  phase <= PH_LOAD;
      endcase
    end
  end

  assert_load_len_R2: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_LOAD && !load_last) |=> phase == PH_LOAD);

  assert_sched_exit_R3: assert property (@(posedge clk) disable iff (rst)
    sched_exit |=> (phase == PH_GEN && sub == 2'd0));

  assert_discard_count_R4: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_GEN && !discard_done) |=> dcnt == DW'($past(dcnt) + DW'(1)));

endmodule

// File: rtl/rc4_sbox.sv
module rc4_sbox
  import rc4_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  phase_t     phase,
  input  logic [1:0] sub,
  input  logic [7:0] key_cur,
  output logic       i_last,
  output logic [7:0] ks_next
);
  logic [7:0] s [SBOX_N];
  logic [7:0] i, j;

  // key-schedule view
  logic [7:0] sw_a, sw_b;
  logic       ksa_add, ksa_swap, ksa_adv;
  // generation view
  logic       gen_fire;
  logic [7:0] i1, j1, ga, gb, t;

  assign sw_a     = s[i];
  assign sw_b     = s[j];
  assign ksa_add  = (phase == PH_SCHED) && (sub == 2'd0);
  assign ksa_swap = (phase == PH_SCHED) && (sub == 2'd1);
  assign ksa_adv  = (phase == PH_SCHED) && (sub == 2'd2);
  assign i_last   = (i == 8'hFF);

  assign gen_fire = (phase == PH_GEN);
  assign i1       = i + 8'd1;
  assign ga       = s[i1];
  assign j1       = j + ga;
  assign gb       = s[j1];
  assign t        = out_index(ga, gb);
  assign ks_next  = post_swap(t, i1, j1, gb, ga, s[t]);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      for (int k = 0; k < SBOX_N; k++) s[k] <= 8'(k);
      i <= '0;
      j <= '0;
    end else if (ksa_add) begin
      j <= sched_j(j, sw_a, key_cur);
    end else if (ksa_swap) begin
      s[i] <= sw_b;
      s[j] <= sw_a;
    end else if (ksa_adv) begin
      i <= i + 8'd1;
      if (i_last) j <= '0;
    end else if (gen_fire) begin
      i     <= i1;
      j     <= j1;
      s[i1] <= gb;
      s[j1] <= ga;
    end
  end

  assert_ksa_swap_R3: assert property (@(posedge clk) disable iff (rst)
    ksa_swap |=> (s[$past(i)] == $past(sw_b) && s[$past(j)] == $past(sw_a)));

  assert_ksa_end_R6: assert property (@(posedge clk) disable iff (rst)
    (ksa_adv && i_last) |=> (i == 8'd0 && j == 8'd0));

  assert_gen_advance_R5: assert property (@(posedge clk) disable iff (rst)
    gen_fire |=> i == 8'($past(i) + 8'd1));

endmodule

// File: rtl/rc4_keystream.sv
module rc4_keystream
  import rc4_pkg::*;
#(
  parameter int KEY_SIZE = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] key_byte,
  output logic [7:0] ks_byte,
  output logic       ks_ready
);
  phase_t     phase;
  logic [1:0] sub;
  logic       discard_done, load_last, i_last;
  logic [7:0] key_cur, ks_next;
  logic       load_en, kstep;

  assign load_en = (phase == PH_LOAD);
  assign kstep   = (phase == PH_SCHED) && (sub == 2'd2);

  rc4_ctrl u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .load_last    (load_last),
    .i_last       (i_last),
    .phase        (phase),
    .sub          (sub),
    .discard_done (discard_done)
  );

  rc4_key_store #(.KEY_SIZE(KEY_SIZE)) u_key (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .key_byte  (key_byte),
    .kstep     (kstep),
    .key_cur   (key_cur),
    .load_last (load_last)
  );

  rc4_sbox u_sbox (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase),
    .sub     (sub),
    .key_cur (key_cur),
    .i_last  (i_last),
    .ks_next (ks_next)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ks_byte  <= '0;
      ks_ready <= 1'b0;
    end else begin
      if (phase == PH_GEN) ks_byte <= ks_next;
      ks_ready <= (phase == PH_GEN) && discard_done;
    end
  end

  assert_ready_holds_R5: assert property (@(posedge clk) disable iff (rst)
    ks_ready |=> ks_ready);

  assert_ready_gen_only_R9: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_GEN) |=> !ks_ready);

endmodule

// File: tb/tb_rc4_keystream.sv
module tb_rc4_keystream;
  localparam int CLK_PERIOD = 10;
  localparam int NB   = 48;
  localparam int DISC = 1536;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic       rst_a = 1'b1, rst_b = 1'b1;
  logic [7:0] key_a = '0, key_b = '0;
  logic [7:0] ks_a, ks_b;
  logic       rdy_a, rdy_b;

  rc4_keystream #(.KEY_SIZE(5)) dut (
    .clk(clk), .rst(rst_a), .key_byte(key_a), .ks_byte(ks_a), .ks_ready(rdy_a));
  rc4_keystream #(.KEY_SIZE(1)) dut_k1 (
    .clk(clk), .rst(rst_b), .key_byte(key_b), .ks_byte(ks_b), .ks_ready(rdy_b));

  int         checks = 0, errors = 0, coll_total = 0;
  logic [7:0] q_a[$], q_b[$];
  logic [7:0] kbuf [16];
  bit         done = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // independent reference: schedule, drop DISC bytes, push NB bytes
  task automatic model(input int which, input int klen);
    int s [256];
    int x, y, t, tmp;
    for (int k = 0; k < 256; k++) s[k] = k;
    y = 0;
    for (int k = 0; k < 256; k++) begin
      y = (y + s[k] + int'(kbuf[k % klen])) % 256;
      tmp = s[k]; s[k] = s[y]; s[y] = tmp;
    end
    x = 0; y = 0;
    for (int n = 0; n < DISC + NB; n++) begin
      x = (x + 1) % 256;
      y = (y + s[x]) % 256;
      tmp = s[x]; s[x] = s[y]; s[y] = tmp;
      t = (s[x] + s[y]) % 256;
      if (n >= DISC) begin
        if (x == y || t == x || t == y) coll_total++;
        if (which == 0) q_a.push_back(8'(s[t]));
        else            q_b.push_back(8'(s[t]));
      end
    end
  endtask

  function automatic bit rdy(input int which);
    return (which == 0) ? rdy_a : rdy_b;
  endfunction

  function automatic int qsize(input int which);
    return (which == 0) ? q_a.size() : q_b.size();
  endfunction

  // driver: reset, load key, measure latency, wait for scoreboard
  task automatic run(input int which, input int klen, input int abort_after);
    int edges;
    if (abort_after == 0) model(which, klen);
    @(negedge clk);
    if (which == 0) begin rst_a = 1'b1; key_a = 8'h00; end
    else            begin rst_b = 1'b1; key_b = 8'h00; end
    repeat (2) @(negedge clk);
    check(rdy(which) == 1'b0, "R1 ready in reset", int'(rdy(which)), 0);
    check(((which == 0) ? ks_a : ks_b) == 8'h00, "R1 byte in reset",
          int'((which == 0) ? ks_a : ks_b), 0);
    if (which == 0) rst_a = 1'b0; else rst_b = 1'b0;
    edges = 0;
    for (int m = 0; m < klen; m++) begin
      if (which == 0) key_a = kbuf[m]; else key_b = kbuf[m];
      @(negedge clk);
      edges++;
    end
    // R2: later key input must be ignored
    if (which == 0) key_a = 8'h5A; else key_b = 8'hC3;
    if (abort_after != 0) begin
      repeat (abort_after) @(negedge clk);
      check(rdy(which) == 1'b0, "R9 ready low in schedule/discard", int'(rdy(which)), 0);
      return;
    end
    while (edges < klen + 2400) begin
      @(negedge clk); #1;
      edges++;
      if (rdy(which)) break;
    end
    check(edges == klen + 2305, "R4 latency to first valid byte", edges, klen + 2305);
    while (qsize(which) > 0) begin
      @(negedge clk); #1;
      if (qsize(which) > 0)
        check(rdy(which) == 1'b1, "R5 ready held", int'(rdy(which)), 1);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst_a && rdy_a && q_a.size() > 0) begin
      automatic logic [7:0] e = q_a.pop_front();
      check(ks_a == e, "R6 keystream byte (key size 5)", int'(ks_a), int'(e));
    end
    if (!rst_b && rdy_b && q_b.size() > 0) begin
      automatic logic [7:0] e = q_b.pop_front();
      check(ks_b == e, "R6 keystream byte (key size 1)", int'(ks_b), int'(e));
    end
  end

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // 5-byte key, mixed values
    kbuf[0] = 8'h4B; kbuf[1] = 8'h65; kbuf[2] = 8'h79; kbuf[3] = 8'h21; kbuf[4] = 8'h9E;
    run(0, 5, 0);
    // all-zero 5-byte key
    for (int m = 0; m < 5; m++) kbuf[m] = 8'h00;
    run(0, 5, 0);
    // 1-byte keys: zero and all ones
    kbuf[0] = 8'h00;
    run(1, 1, 0);
    kbuf[0] = 8'hFF;
    run(1, 1, 0);
    // R8: cut off mid-schedule and mid-discard, then rekey
    for (int m = 0; m < 5; m++) kbuf[m] = 8'hFF;
    run(0, 5, 400);
    run(0, 5, 1500);
    kbuf[0] = 8'h01; kbuf[1] = 8'h23; kbuf[2] = 8'h45; kbuf[3] = 8'h67; kbuf[4] = 8'h89;
    run(0, 5, 0);
    kbuf[0] = 8'h7F;
    run(1, 1, 1000);
    kbuf[0] = 8'h80;
    run(1, 1, 0);
    // R7: the streams must have included colliding steps
    check(coll_total > 0, "R7 collisions exercised", coll_total, 1);
    summary();
    $finish;
  end

endmodule